// File: doc/BRIEF.md
# Two-Word Byte Alignment Unit

This datapath stage returns four consecutive bytes cut out of an eight-byte window. One half of the window is the operand of the current operation. The other half is a word kept from the previous accepted operation. A 2-bit index picks the starting byte, and a per-operation mode bit picks big-endian or little-endian ordering. The mode decides two things: which operand is kept for the next operation, and on which side of the window the kept word sits.

A stream of n aligned words costs n+1 operations. The first operation after reset only fills the kept-word register and gives no result. A two-state controller tracks this. State EMPTY, entered on reset, means no word has been kept yet. State PRIMED means a word is held. Transition PRIME (EMPTY to PRIMED) fires on the first valid operation. Transition CLEAR (any state to EMPTY) fires on synchronous reset. PRIMED otherwise stays PRIMED. The result is registered, so it appears one clock after the operation that produced it.

Top module: `byte_align_unit`

## Requirements
- R1: While `rst` is high and on the first clock after it falls, `res_valid` is 0 and `res_data` is 0x00000000.
- R2: The first operation with `in_valid` high after reset produces no result: `res_valid` stays 0 on the next clock. The kept word is loaded.
- R3: Big-endian (`be_mode`=1) window: the upper word is the kept word and the lower word is the current `opb`. Index 2, kept 0x00010203 and current 0x04050607 give 0x02030405.
- R4: Little-endian (`be_mode`=0) window: the upper word is the current `opa` and the lower word is the kept word. Index 2, kept 0x03020100 and current 0x07060504 give 0x05040302.
- R5: Big-endian result: the 64-bit window {upper,lower} is shifted right by 32, 24, 16 or 8 bits for index 0, 1, 2 or 3, and the low 32 bits are taken.
- R6: Little-endian result: the same window is shifted right by 0, 8, 16 or 24 bits for index 0, 1, 2 or 3, and the low 32 bits are taken.
- R7: A clock with `in_valid` low leaves the kept word unchanged, drives `res_valid` to 0 on the next clock and holds `res_data` at its previous value. Operand, mode and index values on that clock have no effect.
- R8: Once primed, each valid operation drives `res_valid` high with its result exactly one clock later. Back-to-back valid operations give one result per clock.
- R9: A valid operation keeps `opb` when `be_mode`=1 and `opa` when `be_mode`=0. The next operation uses that kept word even if it switches mode.
- R10: A reset in the middle of a stream returns the unit to EMPTY. The next valid operation only primes, and uses no word kept before the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation strobe |
| be_mode | input | 1 | 1 = big-endian, 0 = little-endian |
| align_idx | input | 2 | Start byte index 0..3 |
| opa | input | 32 | A operand |
| opb | input | 32 | B operand |
| res_valid | output | 1 | Result strobe, one clock after the operation |
| res_data | output | 32 | Aligned result |

## Verification
The unit is driven with the two worked streams, one per mode at index 2, and then with streams that step through all four indices in each mode. These show that the shift amounts and the window sides are correct per mode and not mirrored. Idle clocks carrying garbage operands between valid operations separate a correct enable on the kept word from one that loads every clock. Mode switches in mid-stream show which operand was kept. A reset inside a stream checks that priming starts again. A pseudo-random sweep over modes, indices and gaps then compares every result with a byte-indexed reference model.

// File: rtl/byte_align_pkg.sv
package byte_align_pkg;
    typedef enum logic [0:0] {
        ST_EMPTY  = 1'b0,
        ST_PRIMED = 1'b1
    } ba_state_e;
endpackage

// File: rtl/byte_align_ctrl.sv
module byte_align_ctrl
    import byte_align_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    output logic primed
);
    ba_state_e state_q;
    ba_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY:  if (in_valid) state_d = ST_PRIMED;
            ST_PRIMED: state_d = ST_PRIMED;
            default:   state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_EMPTY;
        else     state_q <= state_d;
    end

    always_comb begin
        primed = (state_q == ST_PRIMED);
    end

    AST_STAY_PRIMED: assert property (@(posedge clk) disable iff (rst)
        primed |=> primed); // R8
    AST_PRIME_ON_VALID: assert property (@(posedge clk) disable iff (rst)
        (!primed && in_valid) |=> primed); // R2
endmodule

// File: rtl/byte_align_hold.sv
module byte_align_hold #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic         be_mode,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic [W-1:0] saved
);
    logic [W-1:0] pick;

    always_comb begin
        pick = be_mode ? opb : opa;
    end

    always_ff @(posedge clk) begin
        if (rst)           saved <= '0;
        else if (in_valid) saved <= pick;
    end

    AST_SAVED_STABLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(saved)); // R7
endmodule

// File: rtl/byte_align_shift.sv
module byte_align_shift #(
    parameter int W = 32
) (
    input  logic                   be_mode,
    input  logic [$clog2(W/8)-1:0] align_idx,
    input  logic [W-1:0]           saved,
    input  logic [W-1:0]           opa,
    input  logic [W-1:0]           opb,
    output logic [W-1:0]           aligned
);
    localparam int NB = W / 8;

    logic [2*W-1:0] win_be;
    logic [2*W-1:0] win_le;
    logic [W-1:0]   cand_be [NB];
    logic [W-1:0]   cand_le [NB];

    always_comb begin
        win_be = {saved, opb};
        win_le = {opa, saved};
    end

    for (genvar k = 0; k < NB; k++) begin : g_cand
        logic [2*W-1:0] sh_be;
        logic [2*W-1:0] sh_le;
        always_comb begin
            sh_be = win_be >> ((NB - k) * 8);
            sh_le = win_le >> (k * 8);
            cand_be[k] = sh_be[W-1:0];
            cand_le[k] = sh_le[W-1:0];
        end
    end

    always_comb begin
        aligned = be_mode ? cand_be[align_idx] : cand_le[align_idx];
    end
endmodule

// File: rtl/byte_align_unit.sv
module byte_align_unit #(
    parameter int W  = 32,
    parameter int IW = $clog2(W / 8)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          be_mode,
    input  logic [IW-1:0] align_idx,
    input  logic [W-1:0]  opa,
    input  logic [W-1:0]  opb,
    output logic          res_valid,
    output logic [W-1:0]  res_data
);
    logic         primed;
    logic [W-1:0] saved;
    logic [W-1:0] aligned;
    logic         fire;

    byte_align_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .primed   (primed)
    );

    byte_align_hold #(.W(W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .be_mode  (be_mode),
        .opa      (opa),
        .opb      (opb),
        .saved    (saved)
    );

    byte_align_shift #(.W(W)) u_shift (
        .be_mode   (be_mode),
        .align_idx (align_idx),
        .saved     (saved),
        .opa       (opa),
        .opb       (opb),
        .aligned   (aligned)
    );

    always_comb begin
        fire = in_valid && primed;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_data  <= '0;
        end else begin
            res_valid <= fire;
            if (fire) res_data <= aligned;
        end
    end

    AST_PRIME_NO_RESULT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !primed) |=> !res_valid); // R2
    AST_IDLE_NO_RESULT: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !res_valid); // R7
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(res_data)); // R7
    AST_RESULT_CAUSE: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(in_valid)); // R8
endmodule

// File: tb/tb_byte_align_unit.sv
module tb_byte_align_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        be_mode = 1'b0;
    logic [1:0]  align_idx = 2'd0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        res_valid;
    logic [31:0] res_data;

    int total = 0;
    int bad = 0;
    bit done = 0;

    bit          qv[$];
    logic [31:0] qd[$];
    string       qt[$];

    bit          m_primed = 0;
    logic [31:0] m_saved = '0;
    logic [31:0] m_last = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    byte_align_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .be_mode(be_mode),
        .align_idx(align_idx), .opa(opa), .opb(opb),
        .res_valid(res_valid), .res_data(res_data)
    );

    function automatic logic [31:0] ref_align(bit be, logic [1:0] idx,
                                              logic [31:0] kept, logic [31:0] cur);
        logic [7:0]  w [8];
        logic [31:0] r;
        r = '0;
        if (be) begin
            for (int i = 0; i < 4; i++) begin
                w[i]   = kept[31-8*i -: 8];
                w[i+4] = cur[31-8*i -: 8];
            end
            for (int j = 0; j < 4; j++) r[31-8*j -: 8] = w[int'(idx)+j];
        end else begin
            for (int i = 0; i < 4; i++) begin
                w[i]   = kept[8*i +: 8];
                w[i+4] = cur[8*i +: 8];
            end
            for (int j = 0; j < 4; j++) r[8*j +: 8] = w[int'(idx)+j];
        end
        return r;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(bit v, bit be, logic [1:0] idx, logic [31:0] a,
                         logic [31:0] b, string tag);
        bit ev;
        @(negedge clk);
        in_valid = v; be_mode = be; align_idx = idx; opa = a; opb = b;
        ev = v && m_primed;
        if (ev) m_last = ref_align(be, idx, m_saved, be ? b : a);
        if (v) begin
            m_saved = be ? b : a;
            m_primed = 1;
        end
        qv.push_back(ev);
        qd.push_back(m_last);
        qt.push_back(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; in_valid = 0;
        repeat (2) @(negedge clk);
        rst = 0;
        m_primed = 0; m_saved = '0; m_last = '0;
    endtask

    always @(posedge clk) begin
        #1;
        if (!rst && qv.size() > 0) begin
            bit          ev;
            logic [31:0] ed;
            string       et;
            ev = qv.pop_front();
            ed = qd.pop_front();
            et = qt.pop_front();
            check({et, " valid"}, {31'd0, res_valid}, {31'd0, ev});
            check({et, " data"}, res_data, ed);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        repeat (3) @(negedge clk);
        check("R1 valid in reset", {31'd0, res_valid}, 32'd0);
        check("R1 data in reset", res_data, 32'd0);
        rst = 0;
        @(posedge clk); #1;
        check("R1 valid after reset", {31'd0, res_valid}, 32'd0);
        check("R1 data after reset", res_data, 32'd0);

        // R3 R2 R8: big-endian stream, index 2
        issue(1, 1, 2, 32'hDEADBEEF, 32'h00010203, "R2 prime");
        issue(1, 1, 2, 32'h11111111, 32'h04050607, "R3");
        issue(1, 1, 2, 32'h22222222, 32'h08090A0B, "R3");
        issue(1, 1, 2, 32'h33333333, 32'h0C0D0E0F, "R8");
        if (ref_align(1, 2, 32'h00010203, 32'h04050607) != 32'h02030405) begin
            total++; bad++; $display("FAIL R3 model actual=mismatch expected=02030405");
        end

        // R4: little-endian stream, index 2
        do_reset();
        issue(1, 0, 2, 32'h03020100, 32'hCAFECAFE, "R2 prime");
        issue(1, 0, 2, 32'h07060504, 32'h0, "R4");
        issue(1, 0, 2, 32'h0B0A0908, 32'h0, "R4");
        issue(1, 0, 2, 32'h0F0E0D0C, 32'h0, "R4");

        // R5: big-endian, all indices
        for (int k = 0; k < 8; k++)
            issue(1, 1, 2'(k), 32'hA5A5A5A5, 32'h10203040 + 32'(k) * 32'h01010101, "R5");
        // R6: little-endian, all indices
        for (int k = 0; k < 8; k++)
            issue(1, 0, 2'(k), 32'h80706050 + 32'(k) * 32'h01020304, 32'h5A5A5A5A, "R6");

        // R7: idle clocks with garbage in between
        issue(1, 1, 1, 32'h0, 32'h11223344, "R7");
        issue(0, 0, 3, 32'hFFFFFFFF, 32'hEEEEEEEE, "R7 idle");
        issue(0, 1, 0, 32'h99999999, 32'h77777777, "R7 idle");
        issue(1, 1, 1, 32'h0, 32'h55667788, "R7");

        // R9: mode switches mid stream
        issue(1, 0, 1, 32'hAABBCCDD, 32'h01010101, "R9");
        issue(1, 1, 3, 32'h02020202, 32'h13579BDF, "R9");
        issue(1, 0, 0, 32'h2468ACE0, 32'h03030303, "R9");

        // R10: reset mid stream
        do_reset();
        @(posedge clk); #1;
        check("R10 valid after reset", {31'd0, res_valid}, 32'd0);
        check("R10 data after reset", res_data, 32'd0);
        issue(1, 1, 0, 32'h0, 32'hFEEDF00D, "R10 prime");
        issue(1, 1, 0, 32'h0, 32'h12345678, "R10");

        // sweep
        lfsr = 32'h1ACE0F93;
        for (int n = 0; n < 300; n++) begin
            logic [31:0] a, b;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            a = lfsr * 32'h9E3779B1;
            b = lfsr ^ 32'h5BD1E995;
            issue(lfsr[3:0] != 4'd0, lfsr[7], lfsr[9:8], a, b,
                  lfsr[7] ? "R5 sweep" : "R6 sweep");
        end
        issue(0, 0, 0, 32'h0, 32'h0, "R7 tail");
        repeat (3) @(posedge clk);
        #2;
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule